// File: doc/BRIEF.md
# DS3 C-bit Overhead Generator

This block sits in the transmit path of a DS3 line in C-bit parity format. It takes a serial bit stream, one bit per cycle in which `bit_en` is high, and tracks where each bit falls in the 4760-bit M-frame. The M-frame is seven subframes of eight 85-bit blocks. The first bit of every block is an overhead position. The block overwrites those positions with framing, parity, alarm, far-end block error, FEAC and data-link bits. Every payload bit passes through unchanged. The output appears one cycle after the bit is accepted.

Payload parity is accumulated across each frame and held for the next frame. There it fills both P-bits and the three C-parity bits. The X-bits report a masked set of alarm conditions. The far-end block error bits come either from a register value or from a C-parity error flag seen during the previous frame. Strobes mark every overhead position and, separately, the data-link and FEAC slots. The upstream data-link and FEAC sources use them to present their next bit in the same cycle. A frame-generation enable turns the block into a pass-through. A separate P-bit enable can keep parity insertion running on its own.

Top module: `ds3_cbit_ohgen`

## Requirements
- R1: A frame is 4760 accepted bits: subframes 1 to 7, each of blocks 0 to 7, each of 85 bits. Offset 0 of every block is overhead. `oh_stb` is high exactly when `bit_en` is high at an overhead position. Each accepted bit appears on `data_out` with `dout_vld` high one cycle later. `dout_vld` is low after a cycle without `bit_en`. Counting starts at subframe 1, block 0, offset 0 after reset.
- R2: With frame generation on, the F-bits in blocks 1, 3, 5 and 7 are 1, 0, 0 and 1. The M-bits in block 0 of subframes 5, 6 and 7 are 0, 1 and 0.
- R3: The P-bits sit in block 0 of subframes 3 and 4. They carry the XOR of all payload bits of the previous frame, or 0 in the first frame after reset. They are written when `frame_gen_en` or `p_gen_en` is high.
- R4: With frame generation on, the three C-bits of subframe 3 carry the same previous-frame parity as the P-bits.
- R5: With frame generation on, the X-bits in block 0 of subframes 1 and 2 are 0 when any alarm is present and enabled, that is when `alarm_in & alarm_mask` is non-zero, and 1 otherwise. The alarm bit order is [0] loss of signal, [1] severely errored frame, [2] loss of frame, [3] AIS.
- R6: With frame generation on, the three C-bits of subframe 4 are the FEBE bits. When `febe_auto` is 0 they equal `febe_val`. When `febe_auto` is 1 they are 0 if `cp_err` was high together with `bit_en` at any bit of the previous frame, and 1 otherwise.
- R7: With frame generation on, the three C-bits of subframe 5 carry `dl_bit`, and `dl_stb` marks them. The third C-bit (block 6) of subframe 1 carries `feac_bit`, and `feac_stb` marks it.
- R8: With frame generation on, all other C-bits are 1: blocks 2 and 4 of subframe 1, and every C-bit of subframes 2, 6 and 7.
- R9: With `frame_gen_en` low, `data_out` equals `data_in` at every position. The only exception is the P-bits, which follow R3 when `p_gen_en` is high.
- R10: Payload bits (offsets 1 to 84) always pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Accept one stream bit this cycle |
| data_in | input | 1 | Incoming serial bit |
| frame_gen_en | input | 1 | Overwrite the overhead positions |
| p_gen_en | input | 1 | Write P-bits even when frame generation is off |
| alarm_in | input | 4 | Alarm conditions present |
| alarm_mask | input | 4 | Alarms allowed to clear the X-bits |
| febe_auto | input | 1 | FEBE from the parity error history |
| febe_val | input | 1 | FEBE value in register mode |
| cp_err | input | 1 | C-parity error detected (taken with bit_en) |
| feac_bit | input | 1 | FEAC bit for its slot |
| dl_bit | input | 1 | Data-link bit for its slot |
| data_out | output | 1 | Outgoing serial bit |
| dout_vld | output | 1 | data_out holds a new bit |
| oh_stb | output | 1 | Current accepted bit is overhead |
| feac_stb | output | 1 | Current accepted bit is the FEAC slot |
| dl_stb | output | 1 | Current accepted bit is a data-link slot |

## Verification
The assertions assume three things about the inputs. `bit_en` marks every line bit, and no bit arrives outside it. `cp_err`, `feac_bit` and `dl_bit` are meaningful only in a cycle with `bit_en`. The control inputs are free of unknowns after reset. The stimulus changes the mode inputs only at frame boundaries. It raises `cp_err` only together with `bit_en`. It draws the alarm, FEAC and data-link values afresh for each accepted bit, and inserts random gaps in `bit_en` to exercise the hold behaviour of the position counter.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;

  typedef enum logic [2:0] {
    OH_NONE,
    OH_X,
    OH_P,
    OH_M,
    OH_F,
    OH_C
  } oh_kind_t;

  typedef enum logic [2:0] {
    CS_ONE,
    CS_PAR,
    CS_FEBE,
    CS_DL,
    CS_FEAC
  } csrc_t;

  // Source of a C-bit, from 0-based subframe and block index
  function automatic csrc_t c_source(input int sub, input int blk);
    csrc_t s;
    case (sub)
      0:       s = (blk == 6) ? CS_FEAC : CS_ONE;
      2:       s = CS_PAR;
      3:       s = CS_FEBE;
      4:       s = CS_DL;
      default: s = CS_ONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  localparam int SW = $clog2(SUBFRAMES),
  localparam int BW = $clog2(BLOCKS),
  localparam int OW = $clog2(BLOCK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  output logic [SW-1:0] sub_idx,
  output logic [BW-1:0] blk_idx,
  output logic          is_oh,
  output logic          frame_last
);

  logic [SW-1:0] sub_q, sub_d;
  logic [BW-1:0] blk_q, blk_d;
  logic [OW-1:0] off_q, off_d;
  logic          off_last, blk_last, sub_last;

  assign off_last = (off_q == OW'(BLOCK_BITS - 1));
  assign blk_last = (blk_q == BW'(BLOCKS - 1));
  assign sub_last = (sub_q == SW'(SUBFRAMES - 1));

  always_comb begin
    sub_d = sub_q;
    blk_d = blk_q;
    off_d = off_q;
    if (bit_en) begin
      if (!off_last) begin
        off_d = off_q + 1'b1;
      end else begin
        off_d = '0;
        if (!blk_last) begin
          blk_d = blk_q + 1'b1;
        end else begin
          blk_d = '0;
          sub_d = sub_last ? '0 : sub_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      blk_q <= '0;
      off_q <= '0;
    end else begin
      sub_q <= sub_d;
      blk_q <= blk_d;
      off_q <= off_d;
    end
  end

  assign sub_idx    = sub_q;
  assign blk_idx    = blk_q;
  assign is_oh      = (off_q == '0);
  assign frame_last = off_last & blk_last & sub_last;

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sub_q) < SUBFRAMES) && (int'(blk_q) < BLOCKS) && (int'(off_q) < BLOCK_BITS));

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_last) |=> (sub_q == '0 && blk_q == '0 && off_q == '0));

  // R1
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({sub_q, blk_q, off_q}));

endmodule

// File: rtl/ds3_oh_decode.sv
module ds3_oh_decode
  import ds3_oh_pkg::*;
#(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  localparam int SW = $clog2(SUBFRAMES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic [SW-1:0] sub_idx,
  input  logic [BW-1:0] blk_idx,
  input  logic          is_oh,
  output oh_kind_t      kind,
  output csrc_t         csrc,
  output logic          fix_val
);

  int sub_i, blk_i;
  assign sub_i = int'(sub_idx);
  assign blk_i = int'(blk_idx);

  always_comb begin
    kind    = OH_NONE;
    csrc    = CS_ONE;
    fix_val = 1'b1;
    if (is_oh) begin
      if (blk_i == 0) begin
        if (sub_i < 2) begin
          kind = OH_X;
        end else if (sub_i < 4) begin
          kind = OH_P;
        end else begin
          kind    = OH_M;
          fix_val = (sub_i == 5);
        end
      end else if (blk_i[0]) begin
        kind    = OH_F;
        fix_val = (blk_i == 1) || (blk_i == BLOCKS - 1);
      end else begin
        kind = OH_C;
        csrc = c_source(sub_i, blk_i);
      end
    end
  end

endmodule

// File: rtl/ds3_parity_track.sv
module ds3_parity_track (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic is_payload,
  input  logic din,
  input  logic frame_last,
  input  logic cp_err,
  output logic par_prev,
  output logic err_prev
);

  logic acc_q, acc_d, par_q, par_d;
  logic err_acc_q, err_acc_d, err_q, err_d;

  always_comb begin
    acc_d     = acc_q;
    par_d     = par_q;
    err_acc_d = err_acc_q;
    err_d     = err_q;
    if (bit_en) begin
      if (is_payload) acc_d = acc_q ^ din;
      err_acc_d = err_acc_q | cp_err;
      if (frame_last) begin
        par_d     = acc_d;
        err_d     = err_acc_d;
        acc_d     = 1'b0;
        err_acc_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      par_q     <= 1'b0;
      err_acc_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      par_q     <= par_d;
      err_acc_q <= err_acc_d;
      err_q     <= err_d;
    end
  end

  assign par_prev = par_q;
  assign err_prev = err_q;

  // R3
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && frame_last) |=> $stable(par_q));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && frame_last) |=> $stable(err_q));

  // R6
  err_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_last && cp_err) |=> err_q);

endmodule

// File: rtl/ds3_cbit_ohgen.sv
module ds3_cbit_ohgen
  import ds3_oh_pkg::*;
#(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  parameter int N_ALARM    = 4,
  localparam int SW = $clog2(SUBFRAMES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               data_in,
  input  logic               frame_gen_en,
  input  logic               p_gen_en,
  input  logic [N_ALARM-1:0] alarm_in,
  input  logic [N_ALARM-1:0] alarm_mask,
  input  logic               febe_auto,
  input  logic               febe_val,
  input  logic               cp_err,
  input  logic               feac_bit,
  input  logic               dl_bit,
  output logic               data_out,
  output logic               dout_vld,
  output logic               oh_stb,
  output logic               feac_stb,
  output logic               dl_stb
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [SW-1:0] sub_idx;
  logic [BW-1:0] blk_idx;
  logic          is_oh, frame_last, fix_val;
  logic          par_prev, err_prev;
  oh_kind_t      kind;
  csrc_t         csrc;

  ds3_frame_pos #(
    .SUBFRAMES (SUBFRAMES),
    .BLOCKS    (BLOCKS),
    .BLOCK_BITS(BLOCK_BITS)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_sync),
    .bit_en    (bit_en),
    .sub_idx   (sub_idx),
    .blk_idx   (blk_idx),
    .is_oh     (is_oh),
    .frame_last(frame_last)
  );

  ds3_oh_decode #(
    .SUBFRAMES(SUBFRAMES),
    .BLOCKS   (BLOCKS)
  ) u_dec (
    .sub_idx(sub_idx),
    .blk_idx(blk_idx),
    .is_oh  (is_oh),
    .kind   (kind),
    .csrc   (csrc),
    .fix_val(fix_val)
  );

  ds3_parity_track u_par (
    .clk       (clk),
    .rst_n     (rst_sync),
    .bit_en    (bit_en),
    .is_payload(!is_oh),
    .din       (data_in),
    .frame_last(frame_last),
    .cp_err    (cp_err),
    .par_prev  (par_prev),
    .err_prev  (err_prev)
  );

  // Overhead value selection
  logic gen_bit, c_bit, x_bit, febe_bit;

  assign x_bit    = ~|(alarm_in & alarm_mask);
  assign febe_bit = febe_auto ? ~err_prev : febe_val;

  always_comb begin
    case (csrc)
      CS_PAR:  c_bit = par_prev;
      CS_FEBE: c_bit = febe_bit;
      CS_DL:   c_bit = dl_bit;
      CS_FEAC: c_bit = feac_bit;
      default: c_bit = 1'b1;
    endcase
  end

  always_comb begin
    gen_bit = data_in;
    if (frame_gen_en) begin
      case (kind)
        OH_X:    gen_bit = x_bit;
        OH_P:    gen_bit = par_prev;
        OH_M:    gen_bit = fix_val;
        OH_F:    gen_bit = fix_val;
        OH_C:    gen_bit = c_bit;
        default: gen_bit = data_in;
      endcase
    end else if (p_gen_en && kind == OH_P) begin
      gen_bit = par_prev;
    end
  end

  // Output register with written-out clock enable
  logic dout_q, dout_d, vld_q, vld_d;

  always_comb begin
    dout_d = dout_q;
    vld_d  = bit_en;
    if (bit_en) dout_d = gen_bit;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      dout_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      vld_q  <= vld_d;
    end
  end

  assign data_out = dout_q;
  assign dout_vld = vld_q;
  assign oh_stb   = bit_en & is_oh;
  assign dl_stb   = bit_en & (kind == OH_C) & (csrc == CS_DL);
  assign feac_stb = bit_en & (kind == OH_C) & (csrc == CS_FEAC);

  // R10
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bit_en && !is_oh) |=> (data_out == $past(data_in)));

  // R9
  gen_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bit_en && !frame_gen_en && !(p_gen_en && kind == OH_P)) |=> (data_out == $past(data_in)));

  // R3
  pbit_par_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bit_en && kind == OH_P && (frame_gen_en || p_gen_en)) |=> (data_out == $past(par_prev)));

  // R6
  febe_auto_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bit_en && frame_gen_en && febe_auto && kind == OH_C && csrc == CS_FEBE)
      |=> (data_out == !$past(err_prev)));

  // R7
  slot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0({dl_stb, feac_stb}) && ((dl_stb || feac_stb) -> oh_stb));

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    bit_en |=> dout_vld);

endmodule

// File: tb/ds3_cbit_ohgen_bench.sv
`timescale 1ns/1ps
module ds3_cbit_ohgen_bench;

  localparam int FRAME = 4760;
  localparam int NF    = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, bit_en, data_in, frame_gen_en, p_gen_en;
  logic [3:0] alarm_in, alarm_mask;
  logic       febe_auto, febe_val, cp_err, feac_bit, dl_bit;
  logic       data_out, dout_vld, oh_stb, feac_stb, dl_stb;

  ds3_cbit_ohgen u_ds3_cbit_ohgen (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
    .frame_gen_en(frame_gen_en), .p_gen_en(p_gen_en),
    .alarm_in(alarm_in), .alarm_mask(alarm_mask),
    .febe_auto(febe_auto), .febe_val(febe_val), .cp_err(cp_err),
    .feac_bit(feac_bit), .dl_bit(dl_bit),
    .data_out(data_out), .dout_vld(dout_vld), .oh_stb(oh_stb),
    .feac_stb(feac_stb), .dl_stb(dl_stb)
  );

  int   errors = 0;
  int   checks = 0;
  logic ref_par = 1'b0;   // previous-frame parity, bench side
  logic ref_err = 1'b0;   // previous-frame C-parity error, bench side

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int b);
    int off = b % 85, sub = b / 680, blk = (b % 680) / 85;
    if (off != 0) return "R10";
    if (!frame_gen_en) return (blk == 0 && (sub == 2 || sub == 3) && p_gen_en) ? "R3" : "R9";
    if (blk == 0) return (sub < 2) ? "R5" : (sub < 4) ? "R3" : "R2";
    if (blk % 2 == 1) return "R2";
    if (sub == 0 && blk == 6) return "R7";
    if (sub == 2) return "R4";
    if (sub == 3) return "R6";
    if (sub == 4) return "R7";
    return "R8";
  endfunction

  function automatic logic exp_bit(input int b, input logic d);
    int off = b % 85, sub = b / 680, blk = (b % 680) / 85;
    logic is_p = (off == 0) && (blk == 0) && (sub == 2 || sub == 3);
    if (off != 0) return d;
    if (!frame_gen_en) return (is_p && p_gen_en) ? ref_par : d;
    if (blk == 0) begin
      if (sub < 2) return ((alarm_in & alarm_mask) == 4'd0);
      if (sub < 4) return ref_par;
      return (sub == 5);
    end
    if (blk % 2 == 1) return (blk == 1 || blk == 7);
    case (sub)
      0: return (blk == 6) ? feac_bit : 1'b1;
      2: return ref_par;
      3: return febe_auto ? ~ref_err : febe_val;
      4: return dl_bit;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send(input int b, input logic d, input logic cp);
    logic  e;
    string r;
    int    off = b % 85, sub = b / 680, blk = (b % 680) / 85;
    bit_en   = 1'b1;
    data_in  = d;
    cp_err   = cp;
    alarm_in = 4'($urandom);
    feac_bit = 1'($urandom);
    dl_bit   = 1'($urandom);
    e = exp_bit(b, d);
    r = req_of(b);
    #1;
    chk(oh_stb, off == 0, "R1", "oh_stb");
    chk(dl_stb, off == 0 && sub == 4 && (blk == 2 || blk == 4 || blk == 6), "R7", "dl_stb");
    chk(feac_stb, off == 0 && sub == 0 && blk == 6, "R7", "feac_stb");
    @(negedge clk);
    chk(dout_vld, 1'b1, "R1", "dout_vld");
    chk(data_out, e, r, $sformatf("data_out bit %0d", b));
    bit_en = 1'b0;
    cp_err = 1'b0;
    if ($urandom_range(3) == 0) begin
      @(negedge clk);
      chk(dout_vld, 1'b0, "R1", "dout_vld idle");
      chk(oh_stb, 1'b0, "R1", "oh_stb idle");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    rst_n = 1'b0; bit_en = 1'b0; data_in = 1'b0; frame_gen_en = 1'b1; p_gen_en = 1'b0;
    alarm_in = '0; alarm_mask = '0; febe_auto = 1'b1; febe_val = 1'b0; cp_err = 1'b0;
    feac_bit = 1'b0; dl_bit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout_vld, 1'b0, "R1", "reset dout_vld");
    chk(data_out, 1'b0, "R1", "reset data_out");
    chk(oh_stb, 1'b0, "R1", "reset oh_stb");

    for (int f = 0; f < NF; f++) begin
      int   mode = 0;      // 0 random, 1 all ones, 2 all zeros
      logic errf = 1'b0;
      int   err_pos = $urandom_range(FRAME - 1);
      logic acc = 1'b0, erracc = 1'b0;
      case (f)
        0: begin frame_gen_en = 1; p_gen_en = 0; febe_auto = 1; alarm_mask = 4'hF; end
        1: begin frame_gen_en = 1; febe_auto = 1; errf = 1; mode = 1; alarm_mask = 4'h1; end
        2: begin frame_gen_en = 1; febe_auto = 1; mode = 2; alarm_mask = 4'($urandom); end
        3: begin frame_gen_en = 1; febe_auto = 0; febe_val = 0; errf = 1; end
        4: begin frame_gen_en = 0; p_gen_en = 1; end
        5: begin frame_gen_en = 0; p_gen_en = 0; end
        default: begin frame_gen_en = 1; p_gen_en = 1; febe_auto = 1; alarm_mask = 4'h0; end
      endcase
      for (int b = 0; b < FRAME; b++) begin
        logic d  = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom);
        logic cp = errf && (b == err_pos);
        send(b, d, cp);
        if (b % 85 != 0) acc ^= d;
        erracc |= cp;
      end
      ref_par = acc;
      ref_err = erracc;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule